// File: doc/BRIEF.md
# Serial ADC Channel Scan Sequencer

This block is a serial-bus master for an external eight-input, 12-bit successive-approximation converter. A scan is started with a one-cycle pulse and an enable mask with one bit per input. The sequencer then runs a single chip-select burst of 16-bit frames. Each enabled input is addressed in turn. The conversion results are collected into a densely packed sample array, and a one-cycle completion pulse follows.

The converter pipelines its answers: the reply to a command arrives during the next frame. So the sequencer always appends one frame with an all-zero command, and it throws away whatever arrives during the first frame. A second entry point performs a direct read of one input. That read is two frames long: the addressing frame, then a filler frame whose reply is the sample.

The serial clock is derived from the system clock by a divider that is set from a port. The bus uses mode 3 throughout: the clock idles high, the master changes data on falling edges, and both sides sample on rising edges.

Top module: `spi_adc_scan_seq`

## Requirements
- R1: Serial mode 3. `sclk` is high whenever `cs_n` is high. `mosi` changes only on falling `sclk` edges, and `miso` is captured on rising edges.
- R2: Every frame is 16 bits, sent MSB first. A command frame carries the channel number in bits [13:11], and all other bits are driven 0. The closing filler frame is all zero.
- R3: A scan with N enabled inputs sends exactly N+1 frames. The addressing frames visit the enabled inputs in ascending channel order, and the final frame is the filler.
- R4: The reply to the first frame of a burst is discarded. The reply to frame k (k ≥ 1) becomes sample slot k-1, with slot j at `samples[12*j +: 12]`. `sample_count` equals the number of enabled inputs, and slots beyond it read 0.
- R5: A stored sample is bits [11:0] of the reply word. Whatever the upper four reply bits hold is ignored.
- R6: `cs_n` falls once at the start of a burst and stays low through all frames, which run back to back. It rises once, one half-period after the last rising edge.
- R7: Each `sclk` half-period lasts `sclk_div`+1 system cycles. For a scan started at edge E0, `scan_done` is visible after edge E0 + (32·(N+1)+1)·(`sclk_div`+1).
- R8: An all-zero enable mask sends no frame and leaves `cs_n` high. It pulses `scan_done` right after the start edge, with `sample_count` 0.
- R9: A direct read sends the addressing frame for `rd_chan` followed by one all-zero frame. `rd_data` takes bits [11:0] of the second reply, and `rd_valid` pulses at the same time as `scan_done` would for N=1.
- R10: A `rd_start` while a burst is in progress, or together with `scan_start`, pulses `rd_err_busy` on the next cycle. It has no other effect.
- R11: A `rd_start` with `rd_chan` of 8 or more while idle pulses `rd_err_range` on the next cycle. It sends no frame and leaves `rd_data` unchanged.
- R12: A `scan_start` during a burst is ignored. The burst in progress completes with its original mask.
- R13: `scan_done` and `rd_valid` are single-cycle pulses, and they occur only with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_div | input | 8 | Serial clock half-period minus one, in system cycles |
| scan_start | input | 1 | Pulse that starts a scan burst |
| scan_mask | input | 8 | Per-input enable for the scan |
| rd_start | input | 1 | Pulse that starts a direct read |
| rd_chan | input | 4 | Input number for a direct read |
| busy | output | 1 | A burst is in progress |
| scan_done | output | 1 | Scan completion pulse |
| sample_count | output | 4 | Number of samples stored by the last scan |
| samples | output | 96 | Packed samples, slot j at bits [12*j +: 12] |
| rd_valid | output | 1 | Direct read completion pulse |
| rd_data | output | 12 | Result of the last direct read |
| rd_err_busy | output | 1 | Direct read refused, sequencer busy |
| rd_err_range | output | 1 | Direct read refused, input number out of range |
| sclk | output | 1 | Serial clock, idle high |
| cs_n | output | 1 | Converter select, active low |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Reply data from the converter |

## Verification
Completion timing is checked exactly. A scan of N inputs at divider D must show `scan_done` (32·(N+1)+1)·(D+1) cycles after the start edge, and an empty mask must show it one edge later. The bench counts edges from the start edge and compares the counts against that formula. Refusal pulses are registered once, so the bench samples them at the falling clock edge right after the edge that took `rd_start`. A converter model decodes each 16-bit command on `sclk` rising edges and returns the reply one frame late. The order of addressed inputs and the frame count are therefore checked at the ports, and so is the placement of each sample.

// File: rtl/spi_adc_pkg.sv
`timescale 1ns/1ps
package spi_adc_pkg;
   localparam int FRAME_BITS  = 16;
   localparam int SAMPLE_BITS = 12;
   localparam int ADDR_LSB    = 11;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_TAIL = 2'd2
   } seq_state_t;
endpackage

// File: rtl/spi_adc_clkgen.sv
`timescale 1ns/1ps
// Half-period tick generator for the serial clock.
module spi_adc_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = en && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!en || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_adc_frame.sv
`timescale 1ns/1ps
// One mode-3 frame: drive on falling edge, capture on rising edge.
module spi_adc_frame #(
   parameter int FRAME_W  = 16,
   parameter int SAMPLE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                load,
   input  logic [FRAME_W-1:0]  tx_word,
   input  logic                miso,
   output logic                sclk,
   output logic                mosi,
   output logic                frame_end,
   output logic [SAMPLE_W-1:0] rx_sample
);
   localparam int BC_W = $clog2(FRAME_W);

   logic                active_q;
   logic [BC_W-1:0]     bcnt_q;
   logic [FRAME_W-1:0]  tx_sh_q;
   logic [SAMPLE_W-1:0] rx_sh_q;
   logic                sclk_q;
   logic                mosi_q;
   logic                rise;
   logic                fall;

   generate
      if (SAMPLE_W > FRAME_W) begin : g_bad_width
         $error("sample field wider than frame");
      end
   endgenerate

   assign rise      = active_q && tick && !sclk_q;
   assign fall      = active_q && tick && sclk_q;
   assign frame_end = rise && (bcnt_q == BC_W'(FRAME_W - 1));
   assign rx_sample = {rx_sh_q[SAMPLE_W-2:0], miso};
   assign sclk      = sclk_q;
   assign mosi      = mosi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         bcnt_q   <= '0;
         tx_sh_q  <= '0;
         rx_sh_q  <= '0;
         sclk_q   <= 1'b1;
         mosi_q   <= 1'b0;
      end else begin
         if (fall) begin
            sclk_q  <= 1'b0;
            mosi_q  <= tx_sh_q[FRAME_W-1];
            tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
         end
         if (rise) begin
            sclk_q  <= 1'b1;
            rx_sh_q <= rx_sample;
            bcnt_q  <= bcnt_q + 1'b1;
            if (frame_end)
               active_q <= 1'b0;
         end
         if (load) begin
            tx_sh_q  <= tx_word;
            bcnt_q   <= '0;
            active_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_adc_chan_pick.sv
`timescale 1ns/1ps
// Lowest-numbered set bit of a channel mask.
module spi_adc_chan_pick #(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3
) (
   input  logic [NUM_CH-1:0] mask,
   output logic              found,
   output logic [CH_W-1:0]   idx,
   output logic [NUM_CH-1:0] onehot
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask[i]) begin
            found = 1'b1;
            idx   = CH_W'(i);
         end
      end
      onehot = found ? (NUM_CH'(1) << idx) : '0;
   end
endmodule

// File: rtl/spi_adc_scan_seq.sv
`timescale 1ns/1ps
module spi_adc_scan_seq
   import spi_adc_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int CH_W     = 3,
   parameter int RES_BITS = 12,
   parameter int DIV_W    = 8,
   parameter int CNT_W    = $clog2(NUM_CH + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [DIV_W-1:0]                sclk_div,
   input  logic                            scan_start,
   input  logic [NUM_CH-1:0]               scan_mask,
   input  logic                            rd_start,
   input  logic [CH_W:0]                   rd_chan,
   output logic                            busy,
   output logic                            scan_done,
   output logic [CNT_W-1:0]                sample_count,
   output logic [NUM_CH*SAMPLE_BITS-1:0]   samples,
   output logic                            rd_valid,
   output logic [SAMPLE_BITS-1:0]          rd_data,
   output logic                            rd_err_busy,
   output logic                            rd_err_range,
   output logic                            sclk,
   output logic                            cs_n,
   output logic                            mosi,
   input  logic                            miso
);
   localparam int SW = SAMPLE_BITS;
   localparam int FW = FRAME_BITS;

   generate
      if (NUM_CH != (1 << CH_W)) begin : g_bad_ch
         $error("NUM_CH must equal 2**CH_W");
      end
      if (CH_W + ADDR_LSB > FW - 2) begin : g_bad_addr
         $error("channel field does not fit the command frame");
      end
      if (RES_BITS > SW || RES_BITS < 1) begin : g_bad_res
         $error("RES_BITS out of range");
      end
      if ((1 << CNT_W) <= NUM_CH) begin : g_bad_cnt
         $error("CNT_W too narrow for NUM_CH");
      end
   endgenerate

   seq_state_t        state_q;
   logic              idle;
   logic              tick;
   logic              frame_end;
   logic [SW-1:0]     rx_raw;
   logic [SW-1:0]     rx_trim;
   logic              is_direct_q;
   logic [NUM_CH-1:0] pend_q;
   logic              last_q;
   logic [CNT_W-1:0]  fidx_q;
   logic              cs_n_q;
   logic              chan_ok;
   logic              scan_go;
   logic              rd_go;
   logic              go;
   logic              load;
   logic [NUM_CH-1:0] rd_onehot;
   logic [NUM_CH-1:0] start_mask;
   logic [NUM_CH-1:0] pick_in;
   logic              pick_found;
   logic [CH_W-1:0]   pick_idx;
   logic [NUM_CH-1:0] pick_onehot;
   logic [FW-1:0]     tx_word;

   assign idle       = (state_q == ST_IDLE);
   assign busy       = !idle;
   assign cs_n       = cs_n_q;
   assign chan_ok    = (rd_chan < (CH_W+1)'(NUM_CH));
   assign scan_go    = idle && scan_start;
   assign rd_go      = idle && rd_start && !scan_start && chan_ok;
   assign go         = (scan_go && (|scan_mask)) || rd_go;
   assign rd_onehot  = NUM_CH'(1) << rd_chan[CH_W-1:0];
   assign start_mask = scan_start ? scan_mask : rd_onehot;
   assign pick_in    = idle ? start_mask : pend_q;
   assign load       = go || ((state_q == ST_RUN) && frame_end && !last_q);
   assign tx_word    = pick_found ? (FW'(pick_idx) << ADDR_LSB) : '0;

   spi_adc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (busy),
      .div  (sclk_div),
      .tick (tick)
   );

   spi_adc_frame #(.FRAME_W(FW), .SAMPLE_W(SW)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load),
      .tx_word  (tx_word),
      .miso     (miso),
      .sclk     (sclk),
      .mosi     (mosi),
      .frame_end(frame_end),
      .rx_sample(rx_raw)
   );

   spi_adc_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .mask  (pick_in),
      .found (pick_found),
      .idx   (pick_idx),
      .onehot(pick_onehot)
   );

   // Reduced-resolution converters return zeros below their resolution.
   generate
      if (RES_BITS < SW) begin : g_trim
         assign rx_trim = {rx_raw[SW-1:SW-RES_BITS], {(SW-RES_BITS){1'b0}}};
      end else begin : g_full
         assign rx_trim = rx_raw;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         is_direct_q  <= 1'b0;
         pend_q       <= '0;
         last_q       <= 1'b0;
         fidx_q       <= '0;
         cs_n_q       <= 1'b1;
         scan_done    <= 1'b0;
         rd_valid     <= 1'b0;
         rd_err_busy  <= 1'b0;
         rd_err_range <= 1'b0;
         sample_count <= '0;
         rd_data      <= '0;
      end else begin
         scan_done    <= 1'b0;
         rd_valid     <= 1'b0;
         rd_err_busy  <= rd_start && (!idle || scan_start);
         rd_err_range <= rd_start && idle && !scan_start && !chan_ok;
         if (go) begin
            pend_q <= pick_in & ~pick_onehot;
            last_q <= !pick_found;
            fidx_q <= '0;
         end
         case (state_q)
            ST_IDLE: begin
               if (scan_go) begin
                  sample_count <= '0;
                  if (|scan_mask) begin
                     state_q     <= ST_RUN;
                     is_direct_q <= 1'b0;
                     cs_n_q      <= 1'b0;
                  end else begin
                     scan_done <= 1'b1;
                  end
               end else if (rd_go) begin
                  state_q     <= ST_RUN;
                  is_direct_q <= 1'b1;
                  cs_n_q      <= 1'b0;
               end
            end
            ST_RUN: begin
               if (frame_end) begin
                  fidx_q <= fidx_q + 1'b1;
                  if (fidx_q != '0) begin
                     if (is_direct_q)
                        rd_data <= rx_trim;
                     else
                        sample_count <= sample_count + 1'b1;
                  end
                  if (last_q) begin
                     state_q <= ST_TAIL;
                  end else begin
                     pend_q <= pick_in & ~pick_onehot;
                     last_q <= !pick_found;
                  end
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  state_q <= ST_IDLE;
                  cs_n_q  <= 1'b1;
                  if (is_direct_q)
                     rd_valid <= 1'b1;
                  else
                     scan_done <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Sample slots: frame k's reply lands in slot k-1.
   generate
      for (genvar j = 0; j < NUM_CH; j++) begin : g_slot
         logic [SW-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q <= '0;
            else if (scan_go)
               slot_q <= '0;
            else if ((state_q == ST_RUN) && frame_end && !is_direct_q &&
                     (fidx_q == CNT_W'(j + 1)))
               slot_q <= rx_trim;
         end
         assign samples[j*SW +: SW] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/spi_adc_scan_seq_chk.sv
`timescale 1ns/1ps
module spi_adc_scan_seq_chk #(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scan_start,
   input logic             busy,
   input logic             scan_done,
   input logic             rd_valid,
   input logic             rd_err_busy,
   input logic [CNT_W-1:0] sample_count,
   input logic             sclk,
   input logic             cs_n,
   input logic             mosi
);
   // R1
   sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R1
   mosi_held_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $rose(sclk)) |-> $stable(mosi));

   // R6
   select_within_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   // R13
   done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done || rd_valid) |-> !busy);

   // R4
   count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_count <= CNT_W'(NUM_CH));

   // R10
   busy_refusal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err_busy |-> ($past(busy) || $past(scan_start)));
endmodule

bind spi_adc_scan_seq spi_adc_scan_seq_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scan_start  (scan_start),
   .busy        (busy),
   .scan_done   (scan_done),
   .rd_valid    (rd_valid),
   .rd_err_busy (rd_err_busy),
   .sample_count(sample_count),
   .sclk        (sclk),
   .cs_n        (cs_n),
   .mosi        (mosi)
);

// File: tb/spi_adc_scan_seq_tb.sv
`timescale 1ns/1ps
module spi_adc_scan_seq_tb;
   localparam int NCH = 8;
   localparam int SW  = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    sclk_div = 8'd0;
   logic          scan_start = 1'b0;
   logic [7:0]    scan_mask = 8'd0;
   logic          rd_start = 1'b0;
   logic [3:0]    rd_chan = 4'd0;
   logic          busy, scan_done, rd_valid, rd_err_busy, rd_err_range;
   logic [3:0]    sample_count;
   logic [NCH*SW-1:0] samples;
   logic [SW-1:0] rd_data;
   logic          sclk, cs_n, mosi;
   logic          miso = 1'b0;

   always #2 clk = ~clk;

   spi_adc_scan_seq u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_div(sclk_div),
      .scan_start(scan_start), .scan_mask(scan_mask),
      .rd_start(rd_start), .rd_chan(rd_chan),
      .busy(busy), .scan_done(scan_done), .sample_count(sample_count),
      .samples(samples), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_err_busy(rd_err_busy), .rd_err_range(rd_err_range),
      .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   // ---------------- converter model ----------------
   logic [11:0] m_salt = 12'h000;
   logic [15:0] m_rx = 16'h0;
   logic [15:0] m_reply = 16'hFDEA;
   logic [15:0] m_cmds [16];
   int          m_bits = 0;
   int          m_frames = 0;
   int          m_cs_falls = 0;

   function automatic logic [11:0] ref_val(input logic [2:0] ch, input logic [11:0] salt);
      return ({9'd0, ch} * 12'h111) ^ salt;
   endfunction

   always @(negedge cs_n) begin
      m_bits  = 0;
      m_reply = 16'hFDEA;
      m_cs_falls++;
   end
   always @(negedge sclk) if (cs_n == 1'b0) miso <= m_reply[15 - m_bits];
   always @(posedge sclk) begin
      if (cs_n == 1'b0) begin
         m_rx = {m_rx[14:0], mosi};
         m_bits++;
         if (m_bits == 16) begin
            m_bits = 0;
            if (m_frames < 16) m_cmds[m_frames] = m_rx;
            m_frames++;
            m_reply = {4'hA, ref_val(m_rx[13:11], m_salt)};
         end
      end
   end

   task automatic model_clear();
      m_frames   = 0;
      m_cs_falls = 0;
   endtask

   // ---------------- reporting ----------------
   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         summary();
         $finish;
      end
   end

   // ---------------- stimulus helpers ----------------
   // Drive a scan; count edges from the start edge until scan_done is seen.
   task automatic do_scan(input logic [7:0] mask, input logic [7:0] div, output int cycles);
      @(negedge clk);
      sclk_div   = div;
      scan_mask  = mask;
      scan_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      scan_start = 1'b0;
      cycles = 1;
      while (!scan_done && cycles < 40000) begin
         @(negedge clk);
         cycles++;
      end
   endtask

   task automatic check_scan(input string tag, input logic [7:0] mask, input logic [11:0] salt);
      int n = 0;
      for (int c = 0; c < NCH; c++) begin
         if (mask[c]) begin
            check({tag, " R3 order / R2 cmd"}, m_cmds[n], {2'b00, 3'(c), 11'd0});
            check({tag, " R4/R5 slot"}, samples[n*SW +: SW], ref_val(3'(c), salt));
            n++;
         end
      end
      check({tag, " R3 frame count"}, m_frames, (n == 0) ? 0 : n + 1);
      if (n > 0) check({tag, " R2 filler frame"}, m_cmds[n], 16'h0000);
      check({tag, " R4 sample_count"}, sample_count, n);
      for (int s = n; s < NCH; s++)
         check({tag, " R4 unused slot"}, samples[s*SW +: SW], 0);
      check({tag, " R6 select falls"}, m_cs_falls, (n == 0) ? 0 : 1);
      check({tag, " R1 idle lines"}, {cs_n, sclk}, 2'b11);
   endtask

   // mask, divider, salt
   localparam logic [31:0] VEC [6] = '{
      {8'hFF, 8'h00, 4'h0, 12'h5A5},
      {8'h01, 8'h01, 4'h0, 12'h0F0},
      {8'h80, 8'h02, 4'h0, 12'hFFF},
      {8'hA5, 8'h00, 4'h0, 12'h123},
      {8'h5A, 8'h03, 4'h0, 12'h800},
      {8'h00, 8'h01, 4'h0, 12'h000}
   };

   initial begin
      int cycles;
      int n;
      logic [SW-1:0]     saved_rd;
      logic [NCH*SW-1:0] saved_samples;
      logic              saw_valid;

      repeat (3) @(negedge clk);
      // Reset state
      check("R1 reset sclk", sclk, 1);
      check("R6 reset cs_n", cs_n, 1);
      check("R13 reset busy", busy, 0);
      check("R4 reset count", sample_count, 0);
      check("R4 reset samples", samples, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Table of scan vectors
      for (int v = 0; v < 6; v++) begin
         model_clear();
         m_salt = VEC[v][11:0];
         do_scan(VEC[v][31:24], VEC[v][23:16], cycles);
         n = $countones(VEC[v][31:24]);
         check("R7/R8 done timing", cycles,
               (n == 0) ? 1 : (32 * (n + 1) + 1) * (VEC[v][23:16] + 1) + 1);
         check_scan($sformatf("vec%0d", v), VEC[v][31:24], VEC[v][11:0]);
         @(negedge clk);
         check("R13 done single pulse", scan_done, 0);
      end

      // Direct read of channel 5 (R9), previous samples untouched
      saved_samples = samples;
      model_clear();
      m_salt = 12'h6B1;
      @(negedge clk);
      sclk_div = 8'd2;
      rd_chan  = 4'd5;
      rd_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_start = 1'b0;
      cycles = 1;
      while (!rd_valid && cycles < 40000) begin
         @(negedge clk);
         cycles++;
      end
      check("R9 read timing", cycles, (32 * 2 + 1) * 3 + 1);
      check("R9 rd_data", rd_data, ref_val(3'd5, 12'h6B1));
      check("R9 frames", m_frames, 2);
      check("R9 addressing frame", m_cmds[0], 16'h2800);
      check("R9 filler frame", m_cmds[1], 16'h0000);
      check("R9 samples untouched", samples, saved_samples);
      @(negedge clk);
      check("R13 rd_valid single pulse", rd_valid, 0);

      // Out-of-range channel numbers (R11), boundary 8 and 15
      saved_rd = rd_data;
      for (int k = 0; k < 2; k++) begin
         model_clear();
         @(negedge clk);
         rd_chan  = (k == 0) ? 4'd8 : 4'd15;
         rd_start = 1'b1;
         @(negedge clk);
         rd_start = 1'b0;
         check("R11 range refusal", rd_err_range, 1);
         check("R11 not busy", busy, 0);
         repeat (40) @(negedge clk);
         check("R11 no frame", m_cs_falls, 0);
         check("R11 rd_data kept", rd_data, saved_rd);
      end

      // Busy refusal (R10) and ignored restart (R12)
      model_clear();
      m_salt = 12'h3C3;
      @(negedge clk);
      sclk_div   = 8'd0;
      scan_mask  = 8'hFF;
      scan_start = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      repeat (20) @(negedge clk);
      rd_chan    = 4'd1;
      rd_start   = 1'b1;
      scan_mask  = 8'h01;
      scan_start = 1'b1;
      @(negedge clk);
      rd_start   = 1'b0;
      scan_start = 1'b0;
      check("R10 busy refusal", rd_err_busy, 1);
      saw_valid = 1'b0;
      cycles = 0;
      while (!scan_done && cycles < 40000) begin
         @(negedge clk);
         if (rd_valid) saw_valid = 1'b1;
         cycles++;
      end
      check("R10 no read performed", saw_valid, 0);
      check("R10 rd_data kept", rd_data, saved_rd);
      check_scan("R12 restart ignored", 8'hFF, 12'h3C3);

      // Simultaneous scan and read requests while idle: scan wins (R10)
      model_clear();
      m_salt = 12'h0A0;
      @(negedge clk);
      scan_mask  = 8'h04;
      scan_start = 1'b1;
      rd_chan    = 4'd3;
      rd_start   = 1'b1;
      @(negedge clk);
      scan_start = 1'b0;
      rd_start   = 1'b0;
      check("R10 refusal on collision", rd_err_busy, 1);
      cycles = 0;
      while (!scan_done && cycles < 40000) begin
         @(negedge clk);
         cycles++;
      end
      check_scan("R10 collision scan", 8'h04, 12'h0A0);

      summary();
      $finish;
   end
endmodule